// File: doc/BRIEF.md
# Fracturable Six-Input Lookup Table

This block is a configurable logic element built around a 64-entry truth table. A mode input picks one of two uses. In one use the whole table acts as a single six-input Boolean function. In the other, the table is split into two 32-entry halves that act as two independent five-input functions, both evaluated at once on a shared set of five inputs.

Configuration is written one bit at a time. A write enable, a 6-bit entry index and a data bit are captured on a rising clock edge. The evaluation path has no clock. It is a tree of two-way selectors with one level for each logic input, and the top level is where the table divides into its two halves. Configuration state sits in ordinary flip-flops. These clear to zero on reset and keep their value until a write changes them.

Top module: `frac_lut6`

## Requirements
- R1: While reset is asserted and after it is released, every table entry is 0, so both outputs read 0 for every input pattern in both modes.
- R2: When `cfg_we` is 1 at a rising edge of `clk`, entry number `cfg_addr` (0 to 63) takes the value of `cfg_bit` from that edge onward.
- R3: Until the edge that captures a write, the outputs keep showing the entry's old value, even while `cfg_we`, `cfg_addr` and `cfg_bit` are already applied.
- R4: With `frac_mode` = 0 (whole mode), `out_a` equals entry number `lut_in`, with `lut_in[5]` as the most significant index bit.
- R5: With `frac_mode` = 0, `out_b` is 0.
- R6: With `frac_mode` = 1 (split mode), `out_a` equals entry `lut_in[4:0]` (lower half, indices 0 to 31) and `out_b` equals entry `32 + lut_in[4:0]` (upper half).
- R7: With `frac_mode` = 1, `lut_in[5]` has no effect on either output.
- R8: The outputs follow changes on `lut_in` and `frac_mode` without any clock edge.
- R9: Clock edges with `cfg_we` = 0 leave every table entry unchanged, whatever `cfg_addr` and `cfg_bit` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for configuration writes |
| rst_n | input | 1 | Asynchronous active-low reset; clears the table |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 6 | Index of the table entry to write |
| cfg_bit | input | 1 | Value to store in the addressed entry |
| frac_mode | input | 1 | 0: one six-input function; 1: two five-input functions |
| lut_in | input | 6 | Logic inputs, bit 0 steering the first selector level |
| out_a | output | 1 | Function output (lower half in split mode) |
| out_b | output | 1 | Upper-half output in split mode, 0 in whole mode |

## Verification
The results arrive on two schedules. The function outputs are due in the same cycle as the input or mode change that causes them, with no edge needed. The bench changes `lut_in` or `frac_mode` on a falling edge and samples a few nanoseconds later, before the next rising edge. A table write is due exactly one rising edge after the bench applies it. For that reason the bench samples the addressed entry twice: once before that edge, expecting the old value, and once on the following falling edge, expecting the new value. The all-inputs sweeps are run only after every write of a pattern has been captured, so each sample depends on no clock edge.

// File: rtl/frac_lut6_pkg.sv
package frac_lut6_pkg;
    localparam int unsigned LUT_INPUTS = 6;

    typedef enum logic {
        MODE_WHOLE = 1'b0,
        MODE_SPLIT = 1'b1
    } lut_mode_e;
endpackage

// File: rtl/frac_lut6_cfg_store.sv
module frac_lut6_cfg_store #(
    parameter int unsigned IN_W = frac_lut6_pkg::LUT_INPUTS,
    localparam int unsigned ENTRIES = 2 ** IN_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IN_W-1:0]    wr_addr,
    input  logic               wr_bit,
    output logic [ENTRIES-1:0] table_o
);
    typedef struct packed {
        logic [ENTRIES-1:0] bits;
    } store_t;

    store_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            state_d.bits[wr_addr] = wr_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign table_o = state_q.bits;

    // R2: a write lands in the addressed entry on the capturing edge
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> state_q.bits[$past(wr_addr)] == $past(wr_bit));

    // R9: no enable, no change anywhere in the table
    assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(state_q.bits));
endmodule

// File: rtl/frac_lut6_mux_tree.sv
module frac_lut6_mux_tree #(
    parameter int unsigned LEVELS = 5,
    localparam int unsigned LEAVES = 2 ** LEVELS
) (
    input  logic [LEAVES-1:0] leaves_i,
    input  logic [LEVELS-1:0] sel_i,
    output logic              bit_o
);
    genvar l, j;
    generate
        for (l = 0; l <= LEVELS; l++) begin : g_lvl
            logic [(2 ** (LEVELS - l))-1:0] node;
            if (l == 0) begin : g_leaf
                assign node = leaves_i;
            end else begin : g_pick
                for (j = 0; j < 2 ** (LEVELS - l); j++) begin : g_sel
                    assign node[j] = sel_i[l-1] ? g_lvl[l-1].node[2*j+1]
                                                : g_lvl[l-1].node[2*j];
                end
            end
        end
    endgenerate

    assign bit_o = g_lvl[LEVELS].node[0];
endmodule

// File: rtl/frac_lut6_split.sv
module frac_lut6_split
    import frac_lut6_pkg::*;
(
    input  lut_mode_e mode_i,
    input  logic      top_sel_i,
    input  logic      lo_bit_i,
    input  logic      hi_bit_i,
    output logic      a_o,
    output logic      b_o
);
    always_comb begin
        if (mode_i == MODE_SPLIT) begin
            a_o = lo_bit_i;
            b_o = hi_bit_i;
        end else begin
            a_o = top_sel_i ? hi_bit_i : lo_bit_i;
            b_o = 1'b0;
        end
    end
endmodule

// File: rtl/frac_lut6.sv
module frac_lut6
    import frac_lut6_pkg::*;
#(
    parameter int unsigned IN_W = LUT_INPUTS,
    localparam int unsigned ENTRIES = 2 ** IN_W,
    localparam int unsigned HALF_W  = IN_W - 1,
    localparam int unsigned HALF_N  = ENTRIES / 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [IN_W-1:0] cfg_addr,
    input  logic            cfg_bit,
    input  logic            frac_mode,
    input  logic [IN_W-1:0] lut_in,
    output logic            out_a,
    output logic            out_b
);
    logic [ENTRIES-1:0] cfg_table;
    logic               lo_bit;
    logic               hi_bit;
    lut_mode_e          mode;

    assign mode = lut_mode_e'(frac_mode);

    frac_lut6_cfg_store #(.IN_W(IN_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_addr (cfg_addr),
        .wr_bit  (cfg_bit),
        .table_o (cfg_table)
    );

    frac_lut6_mux_tree #(.LEVELS(HALF_W)) u_tree_lo (
        .leaves_i (cfg_table[HALF_N-1:0]),
        .sel_i    (lut_in[HALF_W-1:0]),
        .bit_o    (lo_bit)
    );

    frac_lut6_mux_tree #(.LEVELS(HALF_W)) u_tree_hi (
        .leaves_i (cfg_table[ENTRIES-1:HALF_N]),
        .sel_i    (lut_in[HALF_W-1:0]),
        .bit_o    (hi_bit)
    );

    frac_lut6_split u_split (
        .mode_i    (mode),
        .top_sel_i (lut_in[IN_W-1]),
        .lo_bit_i  (lo_bit),
        .hi_bit_i  (hi_bit),
        .a_o       (out_a),
        .b_o       (out_b)
    );

    // R4: whole mode reads the full index
    assert_whole_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !frac_mode |-> out_a == cfg_table[lut_in]);

    // R5: second output silent in whole mode
    assert_whole_b_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !frac_mode |-> !out_b);

    // R6 and R7: each split output reads its own half, top input unused
    assert_split_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frac_mode |-> out_a == cfg_table[{1'b0, lut_in[HALF_W-1:0]}]);
    assert_split_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frac_mode |-> out_b == cfg_table[{1'b1, lut_in[HALF_W-1:0]}]);
endmodule

// File: tb/tb_frac_lut6.sv
module tb_frac_lut6;
    localparam int unsigned N = 64;
    localparam logic [63:0] PATS [4] = '{
        64'h0123_4567_89AB_CDEF,
        64'hFFFF_FFFF_0000_0000,
        64'hAAAA_AAAA_5555_5555,
        64'h8000_0000_0000_0001
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [5:0] cfg_addr = '0;
    logic       cfg_bit = 1'b0;
    logic       frac_mode = 1'b0;
    logic [5:0] lut_in = '0;
    logic       out_a, out_b;

    logic [63:0] shadow = '0;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    frac_lut6 dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_bit(cfg_bit), .frac_mode(frac_mode), .lut_in(lut_in),
        .out_a(out_a), .out_b(out_b)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b (mode=%b in=%0d)",
                     req, act, exp, frac_mode, lut_in);
        end
    endtask

    task automatic write_entry(input int idx, input logic v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 6'(idx); cfg_bit = v;
        @(negedge clk);
        cfg_we = 1'b0;
        shadow[idx] = v;
    endtask

    task automatic sweep_all();
        for (int m = 0; m < 2; m++) begin
            for (int i = 0; i < N; i++) begin
                frac_mode = m[0]; lut_in = 6'(i);
                #5;
                if (m == 0) begin
                    chk("R4", out_a, shadow[i]);
                    chk("R5", out_b, 1'b0);
                end else begin
                    chk("R6", out_a, shadow[i % 32]);
                    chk("R6", out_b, shadow[32 + (i % 32)]);
                end
            end
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic a0, b0;
        // R1: reset state, both modes, all inputs
        repeat (2) @(negedge clk);
        for (int i = 0; i < N; i++) begin
            frac_mode = i[0]; lut_in = 6'(i); #2;
            chk("R1", out_a, 1'b0); chk("R1", out_b, 1'b0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        for (int m = 0; m < 2; m++) begin
            for (int i = 0; i < N; i++) begin
                frac_mode = m[0]; lut_in = 6'(i); #2;
                chk("R1", out_a, 1'b0); chk("R1", out_b, 1'b0);
            end
        end

        // R2 / R4 / R5 / R6: vector table of configurations
        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < N; k++) write_entry(k, PATS[p][k]);
            @(negedge clk);
            sweep_all();
        end

        // R3: old value visible until the capturing edge
        @(negedge clk);
        frac_mode = 1'b0; lut_in = 6'd17;
        cfg_we = 1'b1; cfg_addr = 6'd17; cfg_bit = ~shadow[17];
        #5; chk("R3", out_a, shadow[17]);
        @(negedge clk);
        cfg_we = 1'b0;
        shadow[17] = ~shadow[17];
        #2; chk("R2", out_a, shadow[17]);

        // R9: disabled writes leave the table alone
        @(negedge clk);
        cfg_we = 1'b0; cfg_addr = 6'd40; cfg_bit = ~shadow[40];
        frac_mode = 1'b1; lut_in = 6'd8;
        repeat (3) @(negedge clk);
        #2;
        chk("R9", out_b, shadow[40]);
        frac_mode = 1'b0; lut_in = 6'd40; #2;
        chk("R9", out_a, shadow[40]);

        // R7: top input ignored in split mode
        write_entry(3, 1'b1); write_entry(35, 1'b0);
        frac_mode = 1'b1; lut_in = 6'd3; #2;
        a0 = out_a; b0 = out_b;
        lut_in = 6'd35; #2;
        chk("R7", out_a, a0); chk("R7", out_b, b0);
        chk("R7", out_a, 1'b1); chk("R7", out_b, 1'b0);

        // R8: outputs respond between edges, no clock involved
        @(posedge clk); #3;
        frac_mode = 1'b0; lut_in = 6'd3; #1;
        chk("R8", out_a, 1'b1);
        lut_in = 6'd35; #1;
        chk("R8", out_a, 1'b0);
        frac_mode = 1'b1; #1;
        chk("R8", out_a, 1'b1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule